// File: doc/BRIEF.md
# Stream-to-Memory Write DMA with Descriptor Queue

This block moves packets from a valid/ready data stream into memory. Each packet lands at consecutive word addresses, starting at the address held in a descriptor. Software builds a descriptor through a small control write port. One register holds the start address and a second holds the control bits. Writing the go bit commits the staged descriptor into a four-entry queue.

A dispatcher takes one descriptor from the queue for each packet and hands its start address to a write master. The write master turns each accepted stream word into a single memory write on a valid/ready port. The stream stays stalled while the memory side applies back pressure. A descriptor can be marked as parked. When the queue is empty, the dispatcher then re-arms that same descriptor, so the following packet restarts at the same address.

All logic runs on one clock. The stream valid signal only qualifies data words and is never used as a clock. Status outputs show activity, queue occupancy, a sticky overflow flag and a count of completed packets.

Top module: `s2m_dma`

## Requirements
- R1: Words of a packet are written to memory at the descriptor's 32-bit start word address, with the address rising by one for each 16-bit word accepted from the stream.
- R2: While no descriptor is armed, `s_ready_o` stays low and no memory write is issued.
- R3: A control write with `cfg_sel_i`=0 loads the staged start address only and queues nothing.
- R4: A control write with `cfg_sel_i`=1 and data bit 0 set queues one descriptor made of the staged address and park flag (data bit 1). Each packet uses exactly one descriptor, in queue order. A packet ends with the word that has `s_eop_i` high.
- R5: The go bit clears itself one cycle after it is written, so one control write queues at most one descriptor.
- R6: When the armed descriptor had its park flag set and the queue is empty, the dispatcher reuses it, and the next packet starts again at the same address. A queued descriptor always takes priority over reuse.
- R7: While `m_valid_o` is high and `m_ready_i` is low, `m_addr_o` and `m_data_o` hold steady and `s_ready_o` stays low.
- R8: The queue holds four descriptors, and `fifo_full_o` is high when it holds four. A go that arrives while the queue is full is dropped and sets `overflow_o`, which stays set until reset.
- R9: `pkt_count_o` increments by one when the end-of-packet word is accepted by memory.
- R10: After reset, `s_ready_o`, `m_valid_o`, `busy_o`, `fifo_full_o`, `overflow_o` and `pkt_count_o` are zero and `fifo_empty_o` is one. `busy_o` is high while a descriptor is armed or a write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control write strobe |
| cfg_sel_i | input | 1 | 0: staged address, 1: control (bit0 go, bit1 park) |
| cfg_wdata_i | input | 32 | Control write data |
| s_valid_i | input | 1 | Stream word valid |
| s_ready_o | output | 1 | Stream word accepted |
| s_data_i | input | 16 | Stream data word |
| s_eop_i | input | 1 | Last word of packet |
| m_valid_o | output | 1 | Memory write request |
| m_ready_i | input | 1 | Memory write accepted |
| m_addr_o | output | 32 | Memory word address |
| m_data_o | output | 16 | Memory write data |
| busy_o | output | 1 | Descriptor armed or write pending |
| fifo_empty_o | output | 1 | Descriptor queue empty |
| fifo_full_o | output | 1 | Descriptor queue full |
| overflow_o | output | 1 | Sticky: go dropped on full queue |
| pkt_count_o | output | 16 | Completed packet count |

## Verification
The assertions check several properties on every cycle: the write request holds steady under back pressure, the queue is never pushed when full or popped when empty, completion only occurs with an armed descriptor, a dropped go raises overflow, and each completion bumps the packet count. Only the bench scenarios can show the other behaviours. These include the address sequence of each packet against its descriptor, the stalling of a stream with nothing queued, the staged address having no effect alone, the drop of a sixth descriptor, and the parked reuse ending when a new descriptor waits.

// File: rtl/s2m_pkg.sv
package s2m_pkg;
  parameter int unsigned ADDR_W = 32;
  parameter int unsigned DATA_W = 16;
  parameter int unsigned CFG_W  = 32;

  localparam int unsigned GO_BIT   = 0;
  localparam int unsigned PARK_BIT = 1;

  typedef enum logic {
    CFG_ADDR = 1'b0,
    CFG_CTRL = 1'b1
  } cfg_sel_e;

  typedef struct packed {
    logic              park;
    logic [ADDR_W-1:0] addr;
  } desc_t;

  localparam int unsigned DESC_W = $bits(desc_t);
endpackage

// File: rtl/s2m_desc_stage.sv
module s2m_desc_stage
  import s2m_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             cfg_sel_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             fifo_full_i,
  output logic             push_o,
  output desc_t            push_desc_o,
  output logic             overflow_o
);
  logic [ADDR_W-1:0] addr_q;
  logic              park_q;
  logic              go_q;
  logic              ovf_q;
  logic              ctrl_wr;

  assign ctrl_wr = cfg_we_i && (cfg_sel_i == CFG_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      park_q <= 1'b0;
      go_q   <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (cfg_we_i && (cfg_sel_i == CFG_ADDR)) addr_q <= cfg_wdata_i[ADDR_W-1:0];
      if (ctrl_wr) park_q <= cfg_wdata_i[PARK_BIT];
      // go lives for one cycle only
      go_q <= ctrl_wr && cfg_wdata_i[GO_BIT];
      if (go_q && fifo_full_i) ovf_q <= 1'b1;
    end
  end

  assign push_o           = go_q && !fifo_full_i;
  assign push_desc_o.addr = addr_q;
  assign push_desc_o.park = park_q;
  assign overflow_o       = ovf_q;

  // R8
  drop_sets_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_q && fifo_full_i |=> overflow_o);
  // R8
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);
  // R5
  go_self_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_q && !ctrl_wr |=> !push_o);
endmodule

// File: rtl/s2m_desc_fifo.sv
module s2m_desc_fifo #(
  parameter int unsigned WIDTH = 33,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] dout_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign dout_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (push_i) begin
        mem_q[wr_q] <= din_i;
        wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      end
      if (pop_i) rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R8
  no_push_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  // R4
  no_pop_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/s2m_dispatch.sv
module s2m_dispatch
  import s2m_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_empty_i,
  input  desc_t             fifo_desc_i,
  input  logic              done_i,
  output logic              pop_o,
  output logic              load_o,
  output logic [ADDR_W-1:0] load_addr_o,
  output logic              active_o,
  output logic [CNT_W-1:0]  pkt_count_o
);
  logic             active_q;
  logic             last_vld_q;
  desc_t            last_q;
  logic [CNT_W-1:0] cnt_q;
  logic             reissue;

  // queued descriptor wins over parked reuse
  assign pop_o       = !active_q && !fifo_empty_i;
  assign reissue     = !active_q && fifo_empty_i && last_vld_q && last_q.park;
  assign load_o      = pop_o || reissue;
  assign load_addr_o = pop_o ? fifo_desc_i.addr : last_q.addr;
  assign active_o    = active_q;
  assign pkt_count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      last_vld_q <= 1'b0;
      last_q     <= '0;
      cnt_q      <= '0;
    end else begin
      if (load_o) begin
        active_q <= 1'b1;
        if (pop_o) begin
          last_q     <= fifo_desc_i;
          last_vld_q <= 1'b1;
        end
      end else if (done_i) begin
        active_q <= 1'b0;
        cnt_q    <= cnt_q + 1'b1;
      end
    end
  end

  // R4
  done_when_armed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> active_q);
  // R9
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> pkt_count_o == $past(pkt_count_o) + 1'b1);
  // R6
  reuse_needs_park_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o && fifo_empty_i |-> last_vld_q && last_q.park);
endmodule

// File: rtl/s2m_write_master.sv
module s2m_write_master
  import s2m_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              s_valid_i,
  output logic              s_ready_o,
  input  logic [DATA_W-1:0] s_data_i,
  input  logic              s_eop_i,
  output logic              m_valid_o,
  input  logic              m_ready_i,
  output logic [ADDR_W-1:0] m_addr_o,
  output logic [DATA_W-1:0] m_data_o,
  output logic              done_o
);
  logic [ADDR_W-1:0] cur_q, addr_q;
  logic [DATA_W-1:0] data_q;
  logic              hold_q, eop_q;
  logic              take, issue;

  assign s_ready_o = active_i && !hold_q;
  assign take      = s_valid_i && s_ready_o;
  assign issue     = hold_q && m_ready_i;
  assign done_o    = issue && eop_q;
  assign m_valid_o = hold_q;
  assign m_addr_o  = addr_q;
  assign m_data_o  = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      hold_q <= 1'b0;
      eop_q  <= 1'b0;
    end else begin
      if (load_i)    cur_q <= load_addr_i;
      else if (take) cur_q <= cur_q + 1'b1;
      if (take) begin
        hold_q <= 1'b1;
        addr_q <= cur_q;
        data_q <= s_data_i;
        eop_q  <= s_eop_i;
      end else if (issue) begin
        hold_q <= 1'b0;
      end
    end
  end

  // R7
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_valid_o && !m_ready_i |=> m_valid_o && $stable(m_addr_o) && $stable(m_data_o));
  // R2
  take_needs_desc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> !s_ready_o);
endmodule

// File: rtl/s2m_dma.sv
module s2m_dma
  import s2m_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned CNT_W      = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_sel_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              s_valid_i,
  output logic              s_ready_o,
  input  logic [DATA_W-1:0] s_data_i,
  input  logic              s_eop_i,
  output logic              m_valid_o,
  input  logic              m_ready_i,
  output logic [ADDR_W-1:0] m_addr_o,
  output logic [DATA_W-1:0] m_data_o,
  output logic              busy_o,
  output logic              fifo_empty_o,
  output logic              fifo_full_o,
  output logic              overflow_o,
  output logic [CNT_W-1:0]  pkt_count_o
);
  logic              push, pop, load, active, done;
  desc_t             push_desc, head_desc;
  logic [DESC_W-1:0] head_raw;
  logic [ADDR_W-1:0] load_addr;

  assign head_desc = desc_t'(head_raw);

  s2m_desc_stage u_stage (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_sel_i   (cfg_sel_i),
    .cfg_wdata_i (cfg_wdata_i),
    .fifo_full_i (fifo_full_o),
    .push_o      (push),
    .push_desc_o (push_desc),
    .overflow_o  (overflow_o)
  );

  s2m_desc_fifo #(.WIDTH(DESC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .din_i   (push_desc),
    .pop_i   (pop),
    .dout_o  (head_raw),
    .empty_o (fifo_empty_o),
    .full_o  (fifo_full_o)
  );

  s2m_dispatch #(.CNT_W(CNT_W)) u_disp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fifo_empty_i (fifo_empty_o),
    .fifo_desc_i  (head_desc),
    .done_i       (done),
    .pop_o        (pop),
    .load_o       (load),
    .load_addr_o  (load_addr),
    .active_o     (active),
    .pkt_count_o  (pkt_count_o)
  );

  s2m_write_master u_wm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (active),
    .load_i      (load),
    .load_addr_i (load_addr),
    .s_valid_i   (s_valid_i),
    .s_ready_o   (s_ready_o),
    .s_data_i    (s_data_i),
    .s_eop_i     (s_eop_i),
    .m_valid_o   (m_valid_o),
    .m_ready_i   (m_ready_i),
    .m_addr_o    (m_addr_o),
    .m_data_o    (m_data_o),
    .done_o      (done)
  );

  assign busy_o = active || m_valid_o;

  // R7
  stall_under_bp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_valid_o && !m_ready_i |-> !s_ready_o);
endmodule

// File: tb/s2m_dma_test.sv
module s2m_dma_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        s_valid = 1'b0, s_eop = 1'b0, s_ready;
  logic [15:0] s_data = '0;
  logic        m_valid, m_ready = 1'b1;
  logic [31:0] m_addr;
  logic [15:0] m_data;
  logic        busy, f_empty, f_full, ovf;
  logic [15:0] pkt_cnt;

  int n_chk = 0, n_fail = 0;
  int bp_mode = 1; // 0 random, 1 always ready, 2 held off
  logic [47:0] exp_q[$];

  always #5 clk = ~clk;

  s2m_dma uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
    .s_valid_i(s_valid), .s_ready_o(s_ready), .s_data_i(s_data), .s_eop_i(s_eop),
    .m_valid_o(m_valid), .m_ready_i(m_ready), .m_addr_o(m_addr), .m_data_o(m_data),
    .busy_o(busy), .fifo_empty_o(f_empty), .fifo_full_o(f_full),
    .overflow_o(ovf), .pkt_count_o(pkt_cnt)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // monitor: drives m_ready, pops scoreboard on each accepted write
  always @(negedge clk) begin
    if (rst_n) begin
      case (bp_mode)
        0:       m_ready = (($urandom % 4) != 0);
        2:       m_ready = 1'b0;
        default: m_ready = 1'b1;
      endcase
      if (m_valid && m_ready) begin
        if (exp_q.size() == 0) chk("R2 unexpected write", {16'h0, m_addr, m_data}, 64'h0);
        else chk("R1 addr/data", {16'h0, m_addr, m_data}, {16'h0, exp_q.pop_front()});
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  task automatic cfg_write(input logic sel, input logic [31:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic push_desc(input logic [31:0] a, input logic park);
    cfg_write(1'b0, a);
    cfg_write(1'b1, {30'h0, park, 1'b1});
  endtask

  task automatic send_packet(input logic [31:0] start, input int n, input logic [15:0] seed);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back({start + 32'(i), seed + 16'(i)});
      s_valid = 1'b1; s_data = seed + 16'(i); s_eop = (i == n - 1);
      while (!s_ready) @(negedge clk);
      @(negedge clk);
    end
    s_valid = 1'b0; s_eop = 1'b0;
  endtask

  task automatic drain(input bit idle);
    while (exp_q.size() != 0 || (idle && busy)) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic stall_probe(input string req);
    logic seen = 1'b0;
    s_valid = 1'b1; s_data = 16'hdead; s_eop = 1'b1;
    for (int i = 0; i < 10; i++) begin
      if (s_ready) seen = 1'b1;
      @(negedge clk);
    end
    chk(req, 64'(seen), 64'h0);
    s_valid = 1'b0; s_eop = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 reset ready/valid/busy", {s_ready, m_valid, busy}, 3'b000);
    chk("R10 reset fifo/ovf", {f_empty, f_full, ovf}, 3'b100);
    chk("R10 reset count", 64'(pkt_cnt), 64'h0);

    // R2 nothing queued: stream stalls
    stall_probe("R2 stall without descriptor");

    // R3 staged address alone queues nothing
    cfg_write(1'b0, 32'h0000_0100);
    repeat (5) @(negedge clk);
    chk("R3 address write alone", {f_empty, busy, s_ready}, 3'b100);

    // R4 basic packet
    bp_mode = 0;
    push_desc(32'h0000_0100, 1'b0);
    repeat (3) @(negedge clk);
    chk("R4 descriptor armed", {busy, f_empty}, 2'b11);
    send_packet(32'h0000_0100, 5, 16'h1100);
    drain(1);
    chk("R9 count after one packet", 64'(pkt_cnt), 64'h1);
    chk("R10 idle after packet", {busy, f_empty}, 2'b01);

    // R5 one go, one descriptor
    stall_probe("R5 single go gives single descriptor");

    // R7 back pressure
    bp_mode = 2;
    push_desc(32'h0000_0200, 1'b0);
    fork send_packet(32'h0000_0200, 2, 16'h0a00); join_none
    repeat (15) @(negedge clk);
    chk("R7 held request", {m_valid, s_ready, m_addr, m_data}, {2'b10, 32'h0000_0200, 16'h0a00});
    bp_mode = 0;
    wait fork;
    drain(1);

    // R8 fill queue then overflow
    for (int k = 1; k <= 6; k++) push_desc(32'(k) << 12, 1'b0);
    repeat (3) @(negedge clk);
    chk("R8 full and overflow", {f_full, ovf, f_empty}, 3'b110);
    for (int k = 1; k <= 5; k++) send_packet(32'(k) << 12, (k % 4) + 1, 16'(k) << 8);
    drain(1);
    stall_probe("R8 sixth descriptor dropped");
    chk("R8 overflow sticky", {ovf, f_full}, 2'b10);

    // R6 park reuse
    push_desc(32'h0000_8000, 1'b1);
    send_packet(32'h0000_8000, 3, 16'h8000);
    send_packet(32'h0000_8000, 2, 16'h8100);
    drain(0);
    chk("R6 parked descriptor re-armed", {busy, f_empty}, 2'b11);
    push_desc(32'h0000_9000, 1'b0);
    send_packet(32'h0000_8000, 2, 16'h8200);
    send_packet(32'h0000_9000, 2, 16'h9000);
    drain(1);
    stall_probe("R6 reuse ends after plain descriptor");

    // R9 total completions
    chk("R9 total packets", 64'(pkt_cnt), 64'd11);

    summary();
    $finish;
  end
endmodule